// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block controls a set of general-purpose pins through a small word-wide register bus. Each pin property is kept as a bank of 32-bit words, one bit per pin. The properties are direction, drive value, four separate interrupt-enable sets, interrupt polarity, interrupt type and interrupt status. Pin n always uses bit (n mod 32) of the word at its property's base offset plus (n / 32) * 4 bytes. Every property has two words, so the controller covers at most 64 pins. The pin count is set by a parameter, and bits beyond that count do not exist.

Each pin input is resynchronised by two flops before anything uses it. Each pin's detector can be set to level or edge sensitivity, and to high/rising or low/falling polarity. A detected event latches into a sticky status bit. Software clears that bit by writing a 1 to it. Each of the four interrupt outputs is the OR, over all pins, of status ANDed with that output's enable set. Software masks a pin by clearing its enable bit, and the pin's status is kept.

The block has no state machine. Its behaviour is the register file, a two-stage input pipeline, one previous-level flop per pin, and the sticky status register.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero, so `pin_oe`, `pin_out`, `irq_out` and all read data are zero.
- R2: Word offsets are fixed: direction 0x00, drive value 0x08, enable sets 0 to 3 at 0x18, 0x20, 0x28 and 0x30, polarity 0x38, type 0x40, status 0x48. The second word of each property, at base+4, holds pins 32 and up, with pin n in bit n mod 32.
- R3: A write to the direction or drive word changes `pin_oe` or `pin_out` after the next rising edge. A direction bit of 1 means the pin is driven.
- R4: Reading a drive word returns the synchronised pin level, not the written value. A change on `pin_in` shows in that read after the second rising edge.
- R5: With type bit 0 (level), the pin's status is set while the synchronised level is active: high when the polarity bit is 0, low when it is 1. Status appears after the third rising edge following the input change.
- R6: With type bit 1 (edge), polarity 0 sets status on a rising edge and polarity 1 sets it on a falling edge. The status stays set after the input returns.
- R7: Writing 1 to a status bit clears it at the next edge, and 0 bits are unaffected. If the pin is in level mode and its level is still active, the status stays set.
- R8: `irq_out[k]` is high exactly when some pin has both its status bit and its bit in enable set k set. Clearing the enable bit removes the interrupt but keeps the status.
- R9: Bits for pins at or above `NUM_PINS` read as zero and ignore writes.
- R10: Writes to reserved or misaligned offsets change nothing, and reads of them return zero. Reserved offsets are 0x10, 0x14, anything at or above 0x50, and any offset whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin levels seen at the pads |
| pin_out | output | NUM_PINS | Value driven onto each pin |
| pin_oe | output | NUM_PINS | Drive enable per pin, 1 = output |
| irq_out | output | 4 | One interrupt line per enable set |

## Verification
Register writes show on the ports and in read data one rising edge after the strobe. A status clear also lands one edge after its write. A pin change reaches the drive-word read after two edges, and reaches status and the interrupt lines after three. The bench drives all inputs and samples all outputs at the falling edge. Its cycle model advances only on the rising edge, so every comparison falls exactly on the cycle where a result becomes due. The directed latency checks confirm that the values are absent one cycle before that cycle and present in it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int WORD_W   = 32;
    localparam int N_IRQ    = 4;
    localparam int MAX_PINS = 64;

    // Property index = byte offset bits [6:3]
    typedef enum logic [3:0] {
        F_DIR  = 4'd0,
        F_DRV  = 4'd1,
        F_EN0  = 4'd3,
        F_EN1  = 4'd4,
        F_EN2  = 4'd5,
        F_EN3  = 4'd6,
        F_POL  = 4'd7,
        F_TYPE = 4'd8,
        F_STAT = 4'd9
    } prop_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= raw_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] edge_mode_i,
    input  logic [W-1:0] pol_low_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] active;
    logic [W-1:0] evt;

    // Active means "at the selected polarity" for both modes
    assign active = level_i ^ pol_low_i;
    // Edge mode additionally needs the previous sample inactive
    assign evt    = active & (~edge_mode_i | ~(prev_q ^ pol_low_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_o <= '0;
        end else begin
            prev_q <= level_i;
            stat_o <= (stat_o & ~clr_i) | evt;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R6: an edge-latched status survives until explicitly cleared
        p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode_i[i] && stat_o[i] && !clr_i[i]) |=> stat_o[i]);
        // R7: a clear with no competing event empties the bit
        p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !active[i]) |=> !stat_o[i]);
        // R5: an active level always lands in status, clear or not
        p_level_reassert_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_mode_i[i] && active[i]) |=> stat_o[i]);
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [WORD_W-1:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]               level_i,
    input  logic [NUM_PINS-1:0]               stat_i,
    output logic [NUM_PINS-1:0]               dir_o,
    output logic [NUM_PINS-1:0]               drv_o,
    output logic [NUM_PINS-1:0]               pol_o,
    output logic [NUM_PINS-1:0]               type_o,
    output logic [N_IRQ-1:0][NUM_PINS-1:0]    en_o,
    output logic [NUM_PINS-1:0]               clr_o
);
    localparam int WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W = WORDS * WORD_W;

    prop_e             prop;
    logic              word_sel;
    logic              hit_ok;
    logic              wr_ok;
    logic [5:0]        shamt;
    logic [PAD_W-1:0]  lane_ones, lane_data, wmask_pad, wval_pad;
    logic [PAD_W-1:0]  rd_pad, rd_shift;
    logic [NUM_PINS-1:0] wmask, wval, rd_src;
    logic              rd_valid;
    logic [N_IRQ-1:0]  wr_en;

    assign prop     = prop_e'(bus_addr[6:3]);
    assign word_sel = bus_addr[2];
    assign hit_ok   = (bus_addr[ADDR_W-1:7] == '0) && (bus_addr[1:0] == 2'b00)
                      && (!word_sel || (WORDS > 1));
    assign wr_ok    = bus_wr && hit_ok;
    assign shamt    = {word_sel, 5'd0};

    always_comb begin
        lane_ones        = '0;
        lane_ones[31:0]  = '1;
        lane_data        = '0;
        lane_data[31:0]  = bus_wdata;
        wmask_pad        = lane_ones << shamt;
        wval_pad         = lane_data << shamt;
    end

    assign wmask = wmask_pad[NUM_PINS-1:0];
    assign wval  = wval_pad[NUM_PINS-1:0];

    always_comb begin
        for (int k = 0; k < N_IRQ; k++) begin
            wr_en[k] = wr_ok && (bus_addr[6:3] == 4'(int'(F_EN0) + k));
        end
    end

    function automatic logic [NUM_PINS-1:0] merge_word(
        input logic [NUM_PINS-1:0] old_v,
        input logic [NUM_PINS-1:0] m,
        input logic [NUM_PINS-1:0] v
    );
        return (old_v & ~m) | (v & m);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o  <= '0;
            drv_o  <= '0;
            pol_o  <= '0;
            type_o <= '0;
            en_o   <= '0;
        end else begin
            if (wr_ok && prop == F_DIR)  dir_o  <= merge_word(dir_o,  wmask, wval);
            if (wr_ok && prop == F_DRV)  drv_o  <= merge_word(drv_o,  wmask, wval);
            if (wr_ok && prop == F_POL)  pol_o  <= merge_word(pol_o,  wmask, wval);
            if (wr_ok && prop == F_TYPE) type_o <= merge_word(type_o, wmask, wval);
            for (int k = 0; k < N_IRQ; k++) begin
                if (wr_en[k]) en_o[k] <= merge_word(en_o[k], wmask, wval);
            end
        end
    end

    // Write-one-to-clear request toward the detectors
    assign clr_o = (wr_ok && prop == F_STAT) ? (wval & wmask) : '0;

    always_comb begin
        rd_valid = 1'b1;
        case (prop)
            F_DIR:   rd_src = dir_o;
            F_DRV:   rd_src = level_i;
            F_EN0:   rd_src = en_o[0];
            F_EN1:   rd_src = en_o[1];
            F_EN2:   rd_src = en_o[2];
            F_EN3:   rd_src = en_o[3];
            F_POL:   rd_src = pol_o;
            F_TYPE:  rd_src = type_o;
            F_STAT:  rd_src = stat_i;
            default: begin
                rd_src   = '0;
                rd_valid = 1'b0;
            end
        endcase
        rd_pad                 = '0;
        rd_pad[NUM_PINS-1:0]   = rd_src;
        rd_shift               = rd_pad >> shamt;
        bus_rdata              = (hit_ok && rd_valid) ? rd_shift[31:0] : '0;
    end

    // R10: a write that misses the map leaves every configuration word alone
    p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_ok) |=> ($stable(dir_o) && $stable(drv_o) && $stable(pol_o)
                                 && $stable(type_o) && $stable(en_o)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [3:0]          irq_out
);
    logic [NUM_PINS-1:0]            level_s;
    logic [NUM_PINS-1:0]            stat_s;
    logic [NUM_PINS-1:0]            pol_s, type_s, clr_s;
    logic [N_IRQ-1:0][NUM_PINS-1:0] en_s;

    gpio_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (level_s)
    );

    gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_i   (level_s),
        .stat_i    (stat_s),
        .dir_o     (pin_oe),
        .drv_o     (pin_out),
        .pol_o     (pol_s),
        .type_o    (type_s),
        .en_o      (en_s),
        .clr_o     (clr_s)
    );

    gpio_irq_detect #(.W(NUM_PINS)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_i     (level_s),
        .edge_mode_i (type_s),
        .pol_low_i   (pol_s),
        .clr_i       (clr_s),
        .stat_o      (stat_s)
    );

    for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
        assign irq_out[k] = |(stat_s & en_s[k]);
    end

    // R3: bit 0 of a direction write reaches pin 0 after one edge
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (pin_oe[0] == $past(bus_wdata[0])));
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    localparam int NP = 48;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [3:0]    irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Cycle model built from the requirements
    logic [NP-1:0] m_dir, m_drv, m_pol, m_typ, m_stat, m_s1, m_s2, m_prev;
    logic [NP-1:0] m_en [NI];

    always @(posedge clk) begin : model_b
        logic [NP-1:0] evt, wm, wv;
        if (!rst_n) begin
            m_dir = '0; m_drv = '0; m_pol = '0; m_typ = '0; m_stat = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            for (int k = 0; k < NI; k++) m_en[k] = '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (m_typ[i])
                    evt[i] = m_pol[i] ? (m_prev[i] & ~m_s2[i]) : (~m_prev[i] & m_s2[i]);
                else
                    evt[i] = m_pol[i] ? ~m_s2[i] : m_s2[i];
            end
            wm = '0; wv = '0;
            for (int i = 0; i < NP; i++) begin
                if ((i / 32) == int'(bus_addr[2])) begin
                    wm[i] = 1'b1;
                    wv[i] = bus_wdata[i % 32];
                end
            end
            if (bus_wr && (bus_addr == 8'h48 || bus_addr == 8'h4C))
                m_stat = (m_stat & ~(wm & wv)) | evt;
            else
                m_stat = m_stat | evt;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00, 8'h04: m_dir   = (m_dir   & ~wm) | (wv & wm);
                    8'h08, 8'h0C: m_drv   = (m_drv   & ~wm) | (wv & wm);
                    8'h18, 8'h1C: m_en[0] = (m_en[0] & ~wm) | (wv & wm);
                    8'h20, 8'h24: m_en[1] = (m_en[1] & ~wm) | (wv & wm);
                    8'h28, 8'h2C: m_en[2] = (m_en[2] & ~wm) | (wv & wm);
                    8'h30, 8'h34: m_en[3] = (m_en[3] & ~wm) | (wv & wm);
                    8'h38, 8'h3C: m_pol   = (m_pol   & ~wm) | (wv & wm);
                    8'h40, 8'h44: m_typ   = (m_typ   & ~wm) | (wv & wm);
                    default: ;
                endcase
            end
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    function automatic logic [31:0] word_of(input logic [NP-1:0] v, input int w);
        logic [31:0] r = '0;
        for (int j = 0; j < 32; j++) begin
            if (w * 32 + j < NP) r[j] = v[w * 32 + j];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        int w = int'(a[2]);
        case (a)
            8'h00, 8'h04: return word_of(m_dir, w);
            8'h08, 8'h0C: return word_of(m_s2, w);
            8'h18, 8'h1C: return word_of(m_en[0], w);
            8'h20, 8'h24: return word_of(m_en[1], w);
            8'h28, 8'h2C: return word_of(m_en[2], w);
            8'h30, 8'h34: return word_of(m_en[3], w);
            8'h38, 8'h3C: return word_of(m_pol, w);
            8'h40, 8'h44: return word_of(m_typ, w);
            8'h48, 8'h4C: return word_of(m_stat, w);
            default:      return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int k = 0; k < NI; k++) r[k] = |(m_stat & m_en[k]);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " rdata"},  64'(bus_rdata), 64'(exp_rdata(bus_addr)));
        chk({tag, " irq R8"}, 64'(irq_out),   64'(exp_irq()));
        chk({tag, " oe R3"},  64'(pin_oe),    64'(m_dir));
        chk({tag, " out R3"}, 64'(pin_out),   64'(m_drv));
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        step(tag);
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 16)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
            4: return 8'h18;  5: return 8'h1C;  6: return 8'h20;  7: return 8'h28;
            8: return 8'h34;  9: return 8'h38;  10: return 8'h3C; 11: return 8'h40;
            12: return 8'h44; 13: return 8'h48; 14: return 8'h4C;
            default: case ((r / 16) % 3)
                0: return 8'h10;
                1: return 8'h4A;
                default: return 8'hC8;
            endcase
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 oe",    64'(pin_oe),    64'h0);
        chk("R1 irq",   64'(irq_out),   64'h0);
        chk("R1 rdata", 64'(bus_rdata), 64'h0);
        rst_n = 1'b1;
        step("R1");

        // R3: direction and drive words reach the pins
        wr(8'h00, 32'h0000_00F0, "R3 dir");
        chk("R3 dir pin", 64'(pin_oe[7:0]), 64'hF0);
        wr(8'h08, 32'h0000_005A, "R3 drv");
        chk("R3 drv pin", 64'(pin_out[7:0]), 64'h5A);

        // R9: only pins 32..47 exist in the upper word
        wr(8'h04, 32'hFFFF_FFFF, "R9 upper");
        rd(8'h04, "R9 read");
        chk("R9 upper read", 64'(bus_rdata), 64'h0000_FFFF);
        chk("R9 upper pins", 64'(pin_oe[47:32]), 64'hFFFF);

        // R10: reserved and misaligned offsets
        wr(8'h10, 32'hFFFF_FFFF, "R10 reserved");
        rd(8'h10, "R10 read");
        chk("R10 reserved read", 64'(bus_rdata), 64'h0);
        wr(8'h02, 32'hFFFF_FFFF, "R10 misaligned");
        rd(8'h00, "R10 dir kept");
        chk("R10 dir kept", 64'(bus_rdata), 64'h0000_00F0);

        // R4: pin level seen through the drive word after two edges
        bus_addr = 8'h08;
        pin_in[5] = 1'b1;
        step("R4 edge1");
        chk("R4 not yet", 64'(bus_rdata[5]), 64'h0);
        step("R4 edge2");
        chk("R4 level", 64'(bus_rdata[5]), 64'h1);

        // R6: rising edge on pin 3 into enable set 0, latency three edges
        wr(8'h40, 32'h0000_0008, "R6 type");
        wr(8'h18, 32'h0000_0008, "R8 en0");
        pin_in[3] = 1'b1;
        step("R6 e1");
        step("R6 e2");
        chk("R6 before", 64'(irq_out[0]), 64'h0);
        step("R6 e3");
        chk("R6 rising", 64'(irq_out[0]), 64'h1);
        pin_in[3] = 1'b0;
        repeat (4) step("R6 hold");
        chk("R6 sticky", 64'(irq_out[0]), 64'h1);
        // R7: write one clears
        wr(8'h48, 32'h0000_0008, "R7 clear");
        chk("R7 cleared", 64'(irq_out[0]), 64'h0);
        // R6: falling polarity ignores rise, catches fall
        wr(8'h38, 32'h0000_0008, "R6 pol");
        pin_in[3] = 1'b1;
        repeat (4) step("R6 rise ignored");
        chk("R6 rise ignored", 64'(irq_out[0]), 64'h0);
        pin_in[3] = 1'b0;
        repeat (3) step("R6 fall");
        chk("R6 falling", 64'(irq_out[0]), 64'h1);
        wr(8'h48, 32'h0000_0008, "R7 clear2");

        // R5: level high on pin 9 into enable set 1
        wr(8'h20, 32'h0000_0200, "R8 en1");
        pin_in[9] = 1'b1;
        repeat (3) step("R5 level");
        chk("R5 level high", 64'(irq_out[1]), 64'h1);
        wr(8'h48, 32'h0000_0200, "R7 reassert");
        rd(8'h48, "R7 reassert read");
        chk("R7 level reasserts", 64'(bus_rdata[9]), 64'h1);
        // R8: masking keeps status
        wr(8'h20, 32'h0000_0000, "R8 mask");
        chk("R8 masked", 64'(irq_out[1]), 64'h0);
        rd(8'h48, "R8 status kept");
        chk("R8 status kept", 64'(bus_rdata[9]), 64'h1);
        wr(8'h28, 32'h0000_0200, "R8 en2");
        chk("R8 other set", 64'(irq_out[2]), 64'h1);
        pin_in[9] = 1'b0;
        repeat (3) step("R5 drop");
        wr(8'h48, 32'h0000_0200, "R7 final clear");
        rd(8'h48, "R7 read");
        chk("R7 cleared level", 64'(bus_rdata[9]), 64'h0);
        // R5: active-low level
        wr(8'h38, 32'h0000_0200, "R5 pol low");
        repeat (2) step("R5 low");
        rd(8'h48, "R5 low read");
        chk("R5 active low", 64'(bus_rdata[9]), 64'h1);

        // R2: random traffic against the model across the whole map
        for (int c = 0; c < 3000; c++) begin
            if ($urandom % 4 == 0) begin
                bus_wr = 1'b1;
                bus_wdata = $urandom;
            end else begin
                bus_wr = 1'b0;
            end
            bus_addr = pick_addr($urandom);
            if ($urandom % 2 == 0) pin_in[$urandom % NP] ^= 1'b1;
            step("R2 random");
        end
        bus_wr = 1'b0;

        done = 1;
        finish_run();
    end
endmodule